// File: doc/BRIEF.md
# PWM Timer with Staged Duty Compare

This block is an 8-bit up-counting pulse-width generator. It has two compare values. The period compare closes each cycle of the waveform. When the counter reaches it, the counter returns to zero, the output level flips and a one-clock interrupt pulse is raised. The duty compare flips the output part-way through the period and leaves the counter running. The whole block runs on the system clock. The counter advances only on cycles where the count-clock enable input is high, and that enable is produced by a prescaler outside this block.

Software can rewrite the duty value at any moment while the timer runs. Such a write lands in a staging register and does not change the active compare at once. The staged value replaces the active value only on a later duty match against the old value. That match must also fall on the third or a later count tick after the write. This rule keeps a half-applied duty change from producing a runt pulse. While the timer is disabled, a duty write loads both registers at once. The default-level select input decides which output level the timer rests at.

Top module: `pwm_duty_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets its registers. Afterwards the counter is 00H, the period value is FFH, the active and staged duty values are 80H, nothing is pending, `irq_pulse` is 0 and `pwm_out` equals `idle_hi`.
- R2: While `run_en` is 0, the counter is held at 00H and `cnt_tick` has no effect. The first tick after `run_en` rises evaluates count 00H, and the output starts from its default level.
- R3: On each tick while running, the counter increases by one, modulo 256. On a tick where the count equals the period value, the counter becomes 00H, the output inverts, and `irq_pulse` is 1 for exactly the one clock that follows that edge. The waveform period is therefore the period value plus one ticks.
- R4: On a tick where the count equals the active duty value, the output inverts, the counter keeps counting and no interrupt is raised. If both compares match on the same tick, the output inverts only once.
- R5: A duty write while running goes to the staging register. The active duty value stays unchanged until a commit.
- R6: A commit happens only on a duty match tick that is the third or a later tick after the write. The tick in the write cycle itself is not counted. An earlier match inverts the output against the old value and leaves the write pending. From the tick after the commit, the new value is used.
- R7: A further duty write while one is pending replaces the staged value and restarts the three-tick count.
- R8: A duty write while `run_en` is 0 loads the active and staged values together, from the next clock, and clears any pending write.
- R9: A period write takes effect from the next clock in any state. The compare made in the write cycle uses the old value.
- R10: One clock after `run_en` is sampled 0, `pwm_out` equals `idle_hi`, `irq_pulse` is 0 and the counter is 00H.
- R11: `pwm_out` is `idle_hi` XOR the internal phase bit. A 0 on `idle_hi` gives a waveform that rests low and first goes high; a 1 gives the inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Timer enable; 0 holds the timer idle |
| cnt_tick | input | 1 | Count-clock enable, one clock wide per tick |
| idle_hi | input | 1 | Default output level (0 = low) |
| per_wr | input | 1 | Period value write strobe |
| per_data | input | 8 | Period value to write |
| duty_wr | input | 1 | Duty value write strobe |
| duty_data | input | 8 | Duty value to write |
| pwm_out | output | 1 | PWM waveform |
| irq_pulse | output | 1 | One-clock pulse after each period match |

## Verification
The bound checker evaluates these rules on every clock:
- the wrap and interrupt that follow a period match;
- a duty match inverting the output without clearing the counter or raising an interrupt;
- the active duty value changing only on an old-value match that comes at least three ticks after a running write;
- the immediate load on a disabled write;
- the period register update;
- the idle state one clock after disable.

Only the bench's scenarios show the end-to-end waveform under each tick pattern:
- write offsets that land before and after the three-tick limit;
- back-to-back rewrites;
- equal period and duty values;
- the inverted default level;
- the number of interrupts per span of ticks.

// File: rtl/pwm_timer_pkg.sv
// Package: shared types for the PWM timer.
// Assumes: a single system clock domain for every unit of the timer.
package pwm_timer_pkg;

    // Compare events produced on one count tick.
    typedef struct packed {
        logic period_hit;
        logic duty_hit;
    } match_t;

endpackage

// File: rtl/pwm_counter.sv
// Module: up-counter and period compare register.
// The counter advances on each qualified tick while running and returns to
// zero on the tick where it equals the period value.
// Assumes: cnt_tick is a one-clock enable in the clk domain.
module pwm_counter #(
    parameter int W = 8,
    parameter logic [W-1:0] PER_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         cnt_tick,
    input  logic         per_wr,
    input  logic [W-1:0] per_data,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] period_q,
    output logic         period_hit
);

    // Period match: qualified by a running tick.
    assign period_hit = run_en && cnt_tick && (cnt_q == period_q);

    // Period register: written in any state, used from the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PER_RST;
        end else if (per_wr) begin
            period_q <= per_data;
        end
    end

    // Counter: held at zero while idle, wraps on a period match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_en) begin
            cnt_q <= '0;
        end else if (cnt_tick) begin
            if (period_hit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_duty_stage.sv
// Module: active duty register with a staging register and a tick-age guard.
// A running write is held in the staging register. It commits on a match
// against the old active value once MIN_TICKS ticks (the match tick counted)
// have passed since the write.
// Assumes: MIN_TICKS >= 2; cnt_q is the live counter value.
module pwm_duty_stage #(
    parameter int W = 8,
    parameter logic [W-1:0] DUTY_RST = '0,
    parameter int MIN_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         cnt_tick,
    input  logic [W-1:0] cnt_q,
    input  logic         duty_wr,
    input  logic [W-1:0] duty_data,
    output logic [W-1:0] duty_q,
    output logic         duty_hit,
    output logic         pending_q
);

    localparam int AGE_W = (MIN_TICKS > 2) ? $clog2(MIN_TICKS) : 1;
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MIN_TICKS - 1);

    logic [W-1:0]     stage_q;
    logic [AGE_W-1:0] age_q;
    logic             commit;

    // Duty match against the active (old) value.
    assign duty_hit = run_en && cnt_tick && (cnt_q == duty_q);

    // Commit: a pending value that is old enough, on a duty match.
    assign commit = duty_hit && pending_q && (age_q == AGE_MAX);

    // Active register, staging register, pending flag and tick age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q    <= DUTY_RST;
            stage_q   <= DUTY_RST;
            pending_q <= 1'b0;
            age_q     <= '0;
        end else if (!run_en) begin
            age_q <= '0;
            if (duty_wr) begin
                duty_q    <= duty_data;
                stage_q   <= duty_data;
                pending_q <= 1'b0;
            end
        end else begin
            if (commit) begin
                duty_q    <= stage_q;
                pending_q <= 1'b0;
            end
            if (cnt_tick && (age_q != AGE_MAX)) begin
                age_q <= age_q + 1'b1;
            end
            if (duty_wr) begin
                stage_q   <= duty_data;
                pending_q <= 1'b1;
                age_q     <= '0;
            end
        end
    end

endmodule

// File: rtl/pwm_out_stage.sv
// Module: output phase bit and interrupt pulse register.
// The phase flips once on any compare match. The output is the default
// level XOR the phase.
// Assumes: match events are already qualified by a running tick.
module pwm_out_stage
    import pwm_timer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_en,
    input  logic   idle_hi,
    input  match_t hits,
    output logic   pwm_out,
    output logic   irq_pulse
);

    logic phase_q;

    // Phase and interrupt: cleared while idle, updated on matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= 1'b0;
            irq_pulse <= 1'b0;
        end else if (!run_en) begin
            phase_q   <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= hits.period_hit;
            if (hits.period_hit || hits.duty_hit) begin
                phase_q <= ~phase_q;
            end
        end
    end

    // Output level: the default level inverted by the phase.
    assign pwm_out = idle_hi ^ phase_q;

endmodule

// File: rtl/pwm_duty_timer.sv
// Module: PWM timer top. Joins the counter, the duty staging and the output
// stage.
// Assumes: all inputs are synchronous to clk; cnt_tick comes from an external
// prescaler.
module pwm_duty_timer
    import pwm_timer_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] PER_RST = 8'hFF,
    parameter logic [W-1:0] DUTY_RST = 8'h80,
    parameter int MIN_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         cnt_tick,
    input  logic         idle_hi,
    input  logic         per_wr,
    input  logic [W-1:0] per_data,
    input  logic         duty_wr,
    input  logic [W-1:0] duty_data,
    output logic         pwm_out,
    output logic         irq_pulse
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] period_q;
    logic [W-1:0] duty_q;
    logic         pending_q;
    match_t       hits;

    pwm_counter #(.W(W), .PER_RST(PER_RST)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .cnt_tick   (cnt_tick),
        .per_wr     (per_wr),
        .per_data   (per_data),
        .cnt_q      (cnt_q),
        .period_q   (period_q),
        .period_hit (hits.period_hit)
    );

    pwm_duty_stage #(.W(W), .DUTY_RST(DUTY_RST), .MIN_TICKS(MIN_TICKS)) u_duty (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .cnt_tick  (cnt_tick),
        .cnt_q     (cnt_q),
        .duty_wr   (duty_wr),
        .duty_data (duty_data),
        .duty_q    (duty_q),
        .duty_hit  (hits.duty_hit),
        .pending_q (pending_q)
    );

    pwm_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .idle_hi   (idle_hi),
        .hits      (hits),
        .pwm_out   (pwm_out),
        .irq_pulse (irq_pulse)
    );

endmodule

// File: rtl/pwm_duty_timer_chk.sv
// Module: property checker for the PWM timer, bound to the top module.
// Keeps its own count of ticks since the last running duty write.
module pwm_duty_timer_chk #(
    parameter int W = 8,
    parameter int MIN_TICKS = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_en,
    input logic         cnt_tick,
    input logic         idle_hi,
    input logic         per_wr,
    input logic [W-1:0] per_data,
    input logic         duty_wr,
    input logic [W-1:0] duty_data,
    input logic         pwm_out,
    input logic         irq_pulse,
    input logic [W-1:0] cnt,
    input logic [W-1:0] period,
    input logic [W-1:0] duty,
    input logic         pending
);

    int ck_age;

    // Ticks seen since the last running duty write, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            ck_age <= 0;
        end else if (duty_wr) begin
            ck_age <= 0;
        end else if (cnt_tick && ck_age < MIN_TICKS - 1) begin
            ck_age <= ck_age + 1;
        end
    end

    // R3: a period match wraps the counter, pulses the interrupt and flips the output.
    a_r3_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_tick && cnt == period) |=>
            (cnt == '0) && irq_pulse && ((pwm_out ^ idle_hi) != $past(pwm_out ^ idle_hi)));

    // R3: the interrupt only follows a running tick.
    a_r3_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(rst_n) && $past(run_en && cnt_tick));

    // R4: a duty-only match flips the output, keeps counting, no interrupt.
    a_r4_duty_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt_tick && cnt == duty && cnt != period) |=>
            !irq_pulse && (cnt == W'($past(cnt) + 1'b1)) &&
            ((pwm_out ^ idle_hi) != $past(pwm_out ^ idle_hi)));

    // R5 R6: a running change of the active duty value needs an old-value match and enough ticks.
    a_r6_commit_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_en) && !$stable(duty)) |->
            $past(pending) && $past(cnt_tick) && ($past(cnt) == $past(duty)) &&
            ($past(ck_age) >= MIN_TICKS - 1));

    // R8: a disabled duty write loads the active value directly.
    a_r8_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && duty_wr) |=> (duty == $past(duty_data)) && !pending);

    // R9: a period write updates the period register.
    a_r9_period_write: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> period == $past(per_data));

    // R10: one clock after disable the timer rests at the default level.
    a_r10_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (pwm_out == idle_hi) && !irq_pulse && (cnt == '0));

endmodule

bind pwm_duty_timer pwm_duty_timer_chk #(.W(W), .MIN_TICKS(MIN_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cnt_tick  (cnt_tick),
    .idle_hi   (idle_hi),
    .per_wr    (per_wr),
    .per_data  (per_data),
    .duty_wr   (duty_wr),
    .duty_data (duty_data),
    .pwm_out   (pwm_out),
    .irq_pulse (irq_pulse),
    .cnt       (cnt_q),
    .period    (period_q),
    .duty      (duty_q),
    .pending   (pending_q)
);

// File: tb/pwm_duty_timer_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed checks.
module pwm_duty_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       idle_hi = 1'b0;
    logic       per_wr = 1'b0;
    logic [7:0] per_data = 8'h00;
    logic       duty_wr = 1'b0;
    logic [7:0] duty_data = 8'h00;
    logic       pwm_out;
    logic       irq_pulse;

    int    vectors = 0;
    int    fails = 0;
    string cur_tag = "R1";
    int    tick_mode = 0;
    int    tick_ctr = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Reference model state.
    int m_cnt, m_per, m_act, m_stg, m_pend, m_age, m_ph, m_irq;
    int m_nper;
    bit m_pm, m_dm;

    always #2.5 clk = ~clk;

    pwm_duty_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .cnt_tick  (cnt_tick),
        .idle_hi   (idle_hi),
        .per_wr    (per_wr),
        .per_data  (per_data),
        .duty_wr   (duty_wr),
        .duty_data (duty_data),
        .pwm_out   (pwm_out),
        .irq_pulse (irq_pulse)
    );

    // Reference model: updated from the inputs sampled at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 255; m_act = 128; m_stg = 128;
            m_pend = 0; m_age = 0; m_ph = 0; m_irq = 0;
        end else begin
            m_nper = per_wr ? int'(per_data) : m_per;
            if (!run_en) begin
                m_cnt = 0; m_ph = 0; m_irq = 0; m_age = 0;
                if (duty_wr) begin
                    m_act = int'(duty_data); m_stg = int'(duty_data); m_pend = 0;
                end
            end else begin
                m_irq = 0;
                if (cnt_tick) begin
                    m_pm = (m_cnt == m_per);
                    m_dm = (m_cnt == m_act);
                    if (m_pm || m_dm) m_ph = 1 - m_ph;
                    m_irq = m_pm ? 1 : 0;
                    if (m_dm && m_pend == 1 && m_age >= 2) begin
                        m_act = m_stg; m_pend = 0;
                    end
                    m_cnt = m_pm ? 0 : (m_cnt + 1) % 256;
                    if (m_age < 2) m_age = m_age + 1;
                end
                if (duty_wr) begin
                    m_stg = int'(duty_data); m_pend = 1; m_age = 0;
                end
            end
            m_per = m_nper;
        end
    end

    // Count one check; print a failure line on mismatch.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Wait for the falling edge and compare the outputs with the model.
    task automatic step();
        int exp_out;
        @(negedge clk);
        exp_out = int'(idle_hi) ^ m_ph;
        chk(pwm_out === exp_out[0], {cur_tag, " pwm_out"}, int'(pwm_out), exp_out);
        chk(irq_pulse === m_irq[0], {cur_tag, " irq_pulse"}, int'(irq_pulse), m_irq);
    endtask

    // Next tick value for the selected pattern.
    function automatic logic next_tick();
        logic t;
        tick_ctr++;
        case (tick_mode)
            0: t = 1'b1;
            1: t = (tick_ctr % 3) == 0;
            default: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                t = lfsr[0];
            end
        endcase
        return t;
    endfunction

    // One clock: compare, then drive the strobes and tick for the next edge.
    task automatic drive(input bit dw, input int dv, input bit pw, input int pv);
        step();
        duty_wr   = dw;
        duty_data = dv[7:0];
        per_wr    = pw;
        per_data  = pv[7:0];
        cnt_tick  = next_tick();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int nirq;
        // R1 R11: reset state with both default levels.
        cur_tag = "R1";
        step(); step();
        chk(pwm_out === 1'b0, "R1 reset pwm_out", int'(pwm_out), 0);
        chk(irq_pulse === 1'b0, "R1 reset irq_pulse", int'(irq_pulse), 0);
        idle_hi = 1'b1;
        step();
        chk(pwm_out === 1'b1, "R11 reset high default", int'(pwm_out), 1);
        idle_hi = 1'b0;
        rst_n = 1'b1;

        // R2 R8 R9: ticks while idle are ignored; idle writes load directly.
        cur_tag = "R2";
        tick_mode = 0;
        run(8);
        cur_tag = "R8";
        drive(1, 2, 1, 5);
        drive(0, 0, 0, 0);
        cnt_tick = 1'b0;
        step();
        // R3 R4: enable, then count interrupts over 60 ticks.
        cur_tag = "R3";
        run_en = 1'b1; cnt_tick = 1'b1;
        nirq = 0;
        for (int i = 1; i <= 60; i++) begin
            drive(0, 0, 0, 0);
            if (irq_pulse) nirq++;
            if (i == 2) chk(pwm_out === 1'b0, "R4 before duty match", int'(pwm_out), 0);
            if (i == 3) chk(pwm_out === 1'b1, "R4 after duty match", int'(pwm_out), 1);
        end
        chk(nirq == 10, "R3 interrupts in 60 ticks", nirq, 10);

        // R5 R6: running writes at many offsets from the duty match.
        cur_tag = "R6";
        for (int k = 0; k < 12; k++) begin
            drive(1, (k * 3) % 6, 0, 0);
            run(k + 2);
        end
        cur_tag = "R5";
        drive(1, 4, 0, 0);
        run(20);
        // R7: back-to-back rewrites restart the age.
        cur_tag = "R7";
        drive(1, 1, 0, 0);
        drive(1, 3, 0, 0);
        run(1);
        drive(1, 0, 0, 0);
        run(25);

        // R9 R4: sparse ticks, period rewrites, duty equal to period.
        cur_tag = "R9";
        tick_mode = 1;
        drive(0, 0, 1, 7);
        run(40);
        cur_tag = "R4";
        drive(1, 4, 1, 4);
        run(60);

        // R10: disable mid-run.
        cur_tag = "R10";
        tick_mode = 0;
        run(3);
        run_en = 1'b0;
        step();
        chk(pwm_out === idle_hi, "R10 idle output", int'(pwm_out), int'(idle_hi));
        chk(irq_pulse === 1'b0, "R10 idle irq", int'(irq_pulse), 0);

        // R11: inverted default level, random ticks and writes.
        cur_tag = "R11";
        idle_hi = 1'b1;
        drive(1, 9, 1, 20);
        run_en = 1'b1;
        tick_mode = 2;
        for (int k = 0; k < 30; k++) begin
            drive(1, (k * 7) % 21, k % 9 == 0, 14 + k % 7);
            run(4 + k % 11);
        end
        cur_tag = "R2";
        run_en = 1'b0;
        run(4);
        run_en = 1'b1;
        run(80);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule